// File: doc/BRIEF.md
# Serial Audio Receive Word Formatter

This block takes a stereo serial audio stream (bit clock, channel-select clock and one data line) and turns each received channel word into a 24-bit signed sample for the filter path downstream. The serial lines are oversampled in the system clock domain. The system clock must run at least four times faster than the bit clock. Three plain configuration inputs set the following:
- the framing: I2S, right-justified or DSP;
- the incoming word length;
- the bit-clock sampling edge for DSP framing.

Configuration is changed only while the block is held in reset.

Every received word is normalised to 24 bits. A 16-bit or 20-bit word is placed in the top bits and zero-filled below. A 32-bit word loses its lowest 8 bits. Right-justified framing with 32-bit length selected is handled as 24-bit. Data is signed two's complement throughout, so the received MSB always lands on output bit 23.

Samples leave on a valid/ready stream with a channel flag. A presented sample stays on the outputs, unchanged, until the consumer raises ready. The serial link cannot be stalled. If a further sample completes while the output is still occupied and ready is low in that cycle, the new sample is discarded and the held one is kept.

Top module: `aif_rx_formatter`

## Requirements
- R1: After reset `m_valid_o` is low, and it stays low while no complete word has been received.
- R2: Word length code on `cfg_wlen_i`: 00 = 16 bits, 01 = 20 bits, 10 = 24 bits, 11 = 32 bits. A 16-bit word is output as word followed by 8 zero bits. A 20-bit word is output as word followed by 4 zero bits.
- R3: With a 24-bit length the received word is output unchanged. In I2S framing a shorter word sent MSB first with trailing zeros is accepted, provided each channel half lasts at least 25 bit clocks.
- R4: With a 32-bit length, output bits 23..0 are received bits 31..8 and the last 8 received bits are dropped.
- R5: With right-justified framing (`cfg_fmt_i` = 01) and length code 11, the block behaves exactly as with length code 10. Only the last 24 bits of each half are used.
- R6: I2S framing (`cfg_fmt_i` = 00): the MSB is taken on the second active bit-clock edge after a channel-clock transition, and then the following bits in order. Channel clock low marks the left channel (`m_right_o` = 0). Channel clock high marks the right channel (`m_right_o` = 1).
- R7: Right-justified framing: the LSB is the bit taken on the last active edge before a channel-clock transition. The sample is presented after that transition, with the channel of the half that just ended. A half with fewer bits than the word length produces no sample.
- R8: DSP framing (`cfg_fmt_i` = 10 or 11): the channel clock is high for one bit clock to mark a frame. The left word starts, MSB first, on the next active edge. The right word follows directly after the left LSB.
- R9: `cfg_bclk_inv_i` = 0 samples on the rising bit-clock edge and 1 samples on the falling edge. It acts only in DSP framing and is ignored in I2S and right-justified framing.
- R10: A presented sample keeps `m_data_o` and `m_right_o` stable until `m_ready_i` is high. A sample that completes while the output is held and not being accepted is discarded.
- R11: A negative word stays negative: the received MSB appears on `m_data_o[23]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock |
| lrclk_i | input | 1 | Channel-select / frame clock |
| sdata_i | input | 1 | Serial data, MSB first |
| cfg_fmt_i | input | 2 | Framing: 00 I2S, 01 right-justified, 1x DSP |
| cfg_wlen_i | input | 2 | Word length code |
| cfg_bclk_inv_i | input | 1 | Bit-clock edge select for DSP framing |
| m_ready_i | input | 1 | Consumer ready |
| m_valid_o | output | 1 | Sample present |
| m_data_o | output | 24 | Normalised signed sample |
| m_right_o | output | 1 | Channel flag, 1 = right |

## Verification
The hardest situation to reach is the discard rule. A second word has to finish while the first is still unaccepted. The stimulus holds ready low across a whole DSP frame, where left and right complete back to back. It then checks that the left word is still on the outputs and that the right word never appears. The other hard case is a right-justified half that is too short to emit. This is reached with a few bits of the opposite channel sent directly after reset, and the bench then confirms that only the following full frame yields samples. The rest is randomised words over every framing, length and edge setting, with ready toggling at random.

// File: rtl/aif_pkg.sv
package aif_pkg;
  localparam int SAMPLE_W = 24;
  localparam int MAX_W    = 32;
  localparam int LEN_W    = $clog2(MAX_W + 1);

  typedef enum logic [1:0] {
    FRM_I2S = 2'b00,
    FRM_RJ  = 2'b01,
    FRM_DSP = 2'b10,
    FRM_DSX = 2'b11
  } frame_e;

  typedef enum logic [1:0] {
    LEN16 = 2'b00,
    LEN20 = 2'b01,
    LEN24 = 2'b10,
    LEN32 = 2'b11
  } wlen_e;

  // Right-justified framing cannot carry a 32-bit word: fall back to 24.
  function automatic logic [1:0] eff_len(input logic [1:0] wl, input logic [1:0] fmt);
    if (fmt == FRM_RJ && wl == LEN32) return LEN24;
    return wl;
  endfunction

  function automatic logic [LEN_W-1:0] len_bits(input logic [1:0] wl);
    case (wl)
      LEN16:   return LEN_W'(16);
      LEN20:   return LEN_W'(20);
      LEN24:   return LEN_W'(24);
      default: return LEN_W'(32);
    endcase
  endfunction

  // Word arrives right-aligned; left-align it in MAX_W and keep the top bits.
  function automatic logic [SAMPLE_W-1:0] widen(input logic [MAX_W-1:0] w,
                                                 input logic [1:0] wl);
    logic [MAX_W-1:0] aligned;
    aligned = w << (MAX_W - int'(len_bits(wl)));
    return aligned[MAX_W-1 -: SAMPLE_W];
  endfunction
endpackage

// File: rtl/aif_edge_sync.sv
module aif_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic lrclk_i,
  input  logic sdata_i,
  input  logic inv_i,
  output logic edge_o,
  output logic lr_o,
  output logic sd_o
);
  localparam int LINES = 3;

  logic [STAGES-1:0][LINES-1:0] pipe;
  logic                         bclk_prev;
  logic                         bclk_s;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {bclk_i, lrclk_i, sdata_i};
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-2:0], {bclk_i, lrclk_i, sdata_i}};
      end
    end
  endgenerate

  assign bclk_s = pipe[STAGES-1][2];
  assign lr_o   = pipe[STAGES-1][1];
  assign sd_o   = pipe[STAGES-1][0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_prev <= 1'b0;
    else        bclk_prev <= bclk_s;
  end

  // Active edge: bit clock moves to the level opposite the idle one.
  assign edge_o = (bclk_s != bclk_prev) && (bclk_s == !inv_i);
endmodule

// File: rtl/aif_deser.sv
module aif_deser
  import aif_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_i,
  input  logic             lr_i,
  input  logic             sd_i,
  input  logic [1:0]       fmt_i,
  input  logic [1:0]       wl_i,
  output logic             emit_o,
  output logic [MAX_W-1:0] word_o,
  output logic             right_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [MAX_W-1:0] sr, sr_next;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_idx;
  logic             prev_lr, armed, chan;
  logic             lr_change, frame_mark, is_dsp;

  assign is_dsp     = fmt_i[1];
  assign sr_next    = {sr[MAX_W-2:0], sd_i};
  assign lr_change  = lr_i != prev_lr;
  assign frame_mark = lr_i && !prev_lr;
  assign last_idx   = CNT_W'(len_bits(wl_i)) - CNT_W'(1);

  always_comb begin
    emit_o  = 1'b0;
    word_o  = sr_next;
    right_o = 1'b0;
    if (edge_i) begin
      if (is_dsp) begin
        if (!frame_mark && armed && cnt == last_idx) begin
          emit_o  = 1'b1;
          right_o = chan;
        end
      end else if (fmt_i == FRM_RJ) begin
        if (lr_change && cnt >= CNT_W'(len_bits(wl_i))) begin
          emit_o  = 1'b1;
          word_o  = sr;
          right_o = prev_lr;
        end
      end else begin
        if (!lr_change && armed && cnt == last_idx) begin
          emit_o  = 1'b1;
          right_o = prev_lr;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      cnt     <= '0;
      prev_lr <= 1'b0;
      armed   <= 1'b0;
      chan    <= 1'b0;
    end else if (edge_i) begin
      prev_lr <= lr_i;
      sr      <= sr_next;
      if (is_dsp) begin
        if (frame_mark) begin
          armed <= 1'b1;
          cnt   <= '0;
          chan  <= 1'b0;
        end else if (armed) begin
          if (cnt == last_idx) begin
            cnt   <= '0;
            chan  <= 1'b1;
            armed <= !chan;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
      end else if (fmt_i == FRM_RJ) begin
        if (lr_change)            cnt <= CNT_W'(1);
        else if (cnt != CNT_MAX)  cnt <= cnt + CNT_W'(1);
      end else begin
        if (lr_change) begin
          armed <= 1'b1;
          cnt   <= '0;
        end else if (armed) begin
          if (cnt == last_idx) begin
            armed <= 1'b0;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/aif_out_hold.sv
module aif_out_hold #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         right_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  output logic         right_o
);
  logic free;
  assign free = !valid_o || ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      right_o <= 1'b0;
    end else if (free) begin
      valid_o <= load_i;
      if (load_i) begin
        data_o  <= data_i;
        right_o <= right_i;
      end
    end
  end
endmodule

// File: rtl/aif_rx_formatter.sv
module aif_rx_formatter
  import aif_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_i,
  input  logic                lrclk_i,
  input  logic                sdata_i,
  input  logic [1:0]          cfg_fmt_i,
  input  logic [1:0]          cfg_wlen_i,
  input  logic                cfg_bclk_inv_i,
  input  logic                m_ready_i,
  output logic                m_valid_o,
  output logic [SAMPLE_W-1:0] m_data_o,
  output logic                m_right_o
);
  logic                s_edge, s_lr, s_sd, s_inv;
  logic [1:0]          s_wl;
  logic                s_emit, s_chan;
  logic [MAX_W-1:0]    s_raw;
  logic [SAMPLE_W-1:0] s_norm;

  assign s_inv  = cfg_bclk_inv_i && cfg_fmt_i[1];
  assign s_wl   = eff_len(cfg_wlen_i, cfg_fmt_i);
  assign s_norm = widen(s_raw, s_wl);

  aif_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .bclk_i  (bclk_i),
    .lrclk_i (lrclk_i),
    .sdata_i (sdata_i),
    .inv_i   (s_inv),
    .edge_o  (s_edge),
    .lr_o    (s_lr),
    .sd_o    (s_sd)
  );

  aif_deser #(.CNT_W(CNT_W)) u_deser (
    .clk     (clk),
    .rst_n   (rst_n),
    .edge_i  (s_edge),
    .lr_i    (s_lr),
    .sd_i    (s_sd),
    .fmt_i   (cfg_fmt_i),
    .wl_i    (s_wl),
    .emit_o  (s_emit),
    .word_o  (s_raw),
    .right_o (s_chan)
  );

  aif_out_hold #(.W(SAMPLE_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (s_emit),
    .data_i  (s_norm),
    .right_i (s_chan),
    .ready_i (m_ready_i),
    .valid_o (m_valid_o),
    .data_o  (m_data_o),
    .right_o (m_right_o)
  );
endmodule

// File: rtl/aif_rx_chk.sv
module aif_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  fmt,
  input logic [1:0]  eff_wl,
  input logic        edge_s,
  input logic        emit,
  input logic [23:0] norm,
  input logic        m_valid,
  input logic        m_ready,
  input logic [23:0] m_data,
  input logic        m_right
);
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_right));

  p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    emit && (!m_valid || m_ready) |=> m_valid && m_data == $past(norm));

  p_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_ready && !emit |=> !m_valid);

  p_pad16_r2: assert property (@(posedge clk) disable iff (!rst_n)
    emit && eff_wl == 2'b00 |-> norm[7:0] == 8'h00);

  p_pad20_r2: assert property (@(posedge clk) disable iff (!rst_n)
    emit && eff_wl == 2'b01 |-> norm[3:0] == 4'h0);

  p_rj_no32_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fmt == 2'b01 |-> eff_wl != 2'b11);

  p_emit_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> edge_s);
endmodule

bind aif_rx_formatter aif_rx_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .fmt     (cfg_fmt_i),
  .eff_wl  (s_wl),
  .edge_s  (s_edge),
  .emit    (s_emit),
  .norm    (s_norm),
  .m_valid (m_valid_o),
  .m_ready (m_ready_i),
  .m_data  (m_data_o),
  .m_right (m_right_o)
);

// File: tb/sim_aif_rx_formatter.sv
`timescale 1ns/1ps
module sim_aif_rx_formatter;
  localparam int HB = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
  logic [1:0]  fmt = 2'b00, wl = 2'b10;
  logic        pol = 1'b0;
  logic        out_ready = 1'b1;
  logic        m_valid, m_right;
  logic [23:0] m_data;

  int          n_chk = 0, n_fail = 0;
  bit          hold_ready = 1'b0;
  string       cur_req = "R1";
  logic [24:0] expq[$];
  logic [24:0] got;

  always #10 clk = ~clk;

  aif_rx_formatter u0 (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .lrclk_i(lrclk), .sdata_i(sdata),
    .cfg_fmt_i(fmt), .cfg_wlen_i(wl), .cfg_bclk_inv_i(pol), .m_ready_i(out_ready),
    .m_valid_o(m_valid), .m_data_o(m_data), .m_right_o(m_right)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] eff(input logic [1:0] w, input logic [1:0] f);
    return (f == 2'b01 && w == 2'b11) ? 2'b10 : w;
  endfunction

  function automatic int wbits(input logic [1:0] w, input logic [1:0] f);
    case (eff(w, f))
      2'b00: return 16;
      2'b01: return 20;
      2'b10: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic [23:0] exp_norm(input logic [31:0] w, input logic [1:0] wl_i,
                                           input logic [1:0] f);
    case (eff(wl_i, f))
      2'b00: return {w[15:0], 8'h00};
      2'b01: return {w[19:0], 4'h0};
      2'b10: return w[23:0];
      default: return w[31:8];
    endcase
  endfunction

  always begin
    @(posedge clk); #1;
    out_ready = hold_ready ? 1'b0 : ($urandom_range(3) != 0);
  end

  always @(negedge clk) begin
    if (rst_n && m_valid && out_ready) begin
      if (expq.size() == 0) check(1'b0, cur_req, "unexpected sample", {7'd0, m_right, m_data}, 0);
      else begin
        got = expq.pop_front();
        check({m_right, m_data} == got, cur_req, "sample", {7'd0, m_right, m_data}, {7'd0, got});
      end
    end
  end

  task automatic send_bit(input logic l, input logic d);
    logic inv;
    inv = fmt[1] && pol;
    bclk = inv; lrclk = l; sdata = d;
    repeat (HB) @(posedge clk); #1;
    bclk = !inv;
    repeat (HB) @(posedge clk); #1;
  endtask

  task automatic do_reset();
    bclk = 1'b0; lrclk = 1'b0; sdata = 1'b0; rst_n = 1'b0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;
  endtask

  task automatic i2s_frame(input logic [31:0] lw, input logic [31:0] rw, input int slots);
    int n;
    n = wbits(wl, fmt);
    for (int ch = 0; ch < 2; ch++) begin
      logic [31:0] w;
      w = ch ? rw : lw;
      expq.push_back({ch[0], exp_norm(w, wl, fmt)});
      for (int k = 0; k < slots; k++)
        send_bit(ch[0], (k >= 1 && k <= n) ? w[n-k] : 1'b0);
    end
  endtask

  task automatic rj_frame(input logic [31:0] lw, input logic [31:0] rw, input int slots);
    for (int ch = 0; ch < 2; ch++) begin
      logic [31:0] w;
      w = ch ? rw : lw;
      expq.push_back({ch[0], exp_norm(w, wl, fmt)});
      for (int k = 0; k < slots; k++) begin
        int idx;
        idx = slots - 1 - k;
        send_bit(ch[0], (idx < 32) ? w[idx] : 1'b0);
      end
    end
    send_bit(1'b0, 1'b0);
  endtask

  task automatic dsp_frame(input logic [31:0] lw, input logic [31:0] rw, input bit push);
    int n;
    n = wbits(wl, fmt);
    if (push) begin
      expq.push_back({1'b0, exp_norm(lw, wl, fmt)});
      expq.push_back({1'b1, exp_norm(rw, wl, fmt)});
    end
    send_bit(1'b1, 1'b0);
    for (int k = 0; k < n; k++) send_bit(1'b0, lw[n-1-k]);
    for (int k = 0; k < n; k++) send_bit(1'b0, rw[n-1-k]);
    send_bit(1'b0, 1'b0);
    send_bit(1'b0, 1'b0);
  endtask

  task automatic phase_end(input string req);
    repeat (60) @(posedge clk); #1;
    check(expq.size() == 0, req, "all samples delivered", expq.size(), 0);
    expq.delete();
  endtask

  task automatic run_phase(input logic [1:0] f, input logic [1:0] w, input bit p,
                           input string req);
    int n;
    fmt = f; wl = w; pol = p; cur_req = req;
    do_reset();
    n = wbits(wl, fmt);
    if (f == 2'b00) begin
      send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0);
    end
    for (int i = 0; i < 3; i++) begin
      logic [31:0] a, b;
      a = $urandom(); b = $urandom();
      if (f == 2'b00) i2s_frame(a, b, n + 1 + int'($urandom_range(3)));
      else if (f == 2'b01) rj_frame(a, b, ((w == 2'b11) ? 32 : n) + int'($urandom_range(3)));
      else dsp_frame(a, b, 1'b1);
    end
    phase_end(req);
  endtask

  initial begin
    void'($urandom(32'd2718));
    // R1: reset state and no output without a full word
    fmt = 2'b00; wl = 2'b10; cur_req = "R1";
    do_reset();
    check(m_valid == 1'b0, "R1", "valid after reset", m_valid, 0);
    for (int k = 0; k < 12; k++) send_bit(1'b0, 1'b1);
    check(m_valid == 1'b0, "R1", "valid with no word", m_valid, 0);

    // R6 R2 R4 R3: I2S over all lengths, polarity ignored (R9)
    run_phase(2'b00, 2'b00, 1'b0, "R6 R2");
    run_phase(2'b00, 2'b01, 1'b1, "R6 R2 R9");
    run_phase(2'b00, 2'b10, 1'b0, "R6 R3");
    run_phase(2'b00, 2'b11, 1'b0, "R6 R4");

    // R11: sign kept; R3 short word in 24-bit I2S
    fmt = 2'b00; wl = 2'b00; pol = 1'b0; cur_req = "R11";
    do_reset();
    send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0);
    i2s_frame(32'h0000_8000, 32'h0000_7fff, 17);
    phase_end("R11");
    fmt = 2'b00; wl = 2'b10; cur_req = "R3";
    do_reset();
    send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0);
    i2s_frame(32'h00a5_c300, 32'h0081_0100, 25);
    phase_end("R3");

    // R7 R5: right-justified, 32 forced to 24, polarity ignored (R9)
    run_phase(2'b01, 2'b00, 1'b0, "R7 R2");
    run_phase(2'b01, 2'b01, 1'b0, "R7 R2");
    run_phase(2'b01, 2'b10, 1'b1, "R7 R9");
    run_phase(2'b01, 2'b11, 1'b0, "R5");

    // R7: a short half yields no sample
    fmt = 2'b01; wl = 2'b00; pol = 1'b0; cur_req = "R7";
    do_reset();
    for (int k = 0; k < 4; k++) send_bit(1'b1, 1'b1);
    rj_frame(32'h1234_5678, 32'h9abc_def0, 18);
    phase_end("R7");

    // R8 R9: DSP, both edges, both codes
    run_phase(2'b10, 2'b00, 1'b0, "R8");
    run_phase(2'b10, 2'b01, 1'b1, "R8 R9");
    run_phase(2'b11, 2'b10, 1'b1, "R8 R9");
    run_phase(2'b10, 2'b11, 1'b0, "R8 R4");
    run_phase(2'b11, 2'b11, 1'b1, "R8 R9 R4");

    // R10: back-pressure holds left, drops right
    fmt = 2'b10; wl = 2'b00; pol = 1'b0; cur_req = "R10";
    do_reset();
    hold_ready = 1'b1;
    repeat (2) @(posedge clk); #1;
    dsp_frame(32'h0000_c0de, 32'h0000_1111, 1'b0);
    repeat (20) @(posedge clk); #1;
    check(m_valid == 1'b1, "R10", "held valid", m_valid, 1);
    check(m_data == 24'hc0de00, "R10", "held data", m_data, 24'hc0de00);
    check(m_right == 1'b0, "R10", "held channel", m_right, 0);
    expq.push_back({1'b0, 24'hc0de00});
    hold_ready = 1'b0;
    repeat (20) @(posedge clk); #1;
    check(m_valid == 1'b0, "R10", "drained, right dropped", m_valid, 0);
    phase_end("R10");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog %s: actual timeout expected completion", cur_req);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule